// File: doc/BRIEF.md
# Reservation Flag for Linked Load and Conditional Store

This block holds the one-bit reservation that pairs a linked load with a conditional store on a single-core processor. A linked load sets the reservation and reads one 32-bit word from memory. The word is returned as the new value of the destination register.

A conditional store first copies the reservation into the processor's T status bit. It writes the source register to memory only if that copy is 1. The reservation is then always dropped. An interrupt or exception input also drops the reservation at any time. The reservation has no address compare. Success is reported only through T.

The pipeline hands one operation at a time to the block through an instruction strobe. It supplies the address register and the store data with that strobe. It waits on `op_ready` before sending the next operation. Memory is reached through one request port that uses a valid/ready handshake, plus a read-response strobe.

Top module: `llsc_unit`

## Requirements
- R1: After reset, `t_bit` is 0, `op_ready` is 1, `mem_req_valid` is 0 and the reservation is clear, so a first conditional store reports T=0 and writes nothing.
- R2: A linked load (`op_is_store`=0) issues one read of `op_addr`. The word returned on `mem_rsp_data` appears on `ld_data`, with `ld_done` high for one cycle, one cycle after `mem_rsp_valid`.
- R3: An accepted linked load sets the reservation.
- R4: A conditional store (`op_is_store`=1) copies the reservation into `t_bit`. The new value is visible by the cycle in which `st_done` is high, and it holds until the next conditional store.
- R5: When the copied bit is 1, exactly one write of `op_wdata` to `op_addr` is issued. When it is 0, no memory request is issued.
- R6: The reservation is clear after every conditional store, whether it succeeded or failed.
- R7: A high `exc_clear` clears the reservation. This includes the case where the linked load's memory read is still outstanding. `exc_clear` wins over a linked load accepted in the same cycle.
- R8: A linked load accepted while the reservation is already set leaves it set.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request (valid, write flag, address, data) holds unchanged.
- R10: Only one operation is in flight. `op_ready` is low from the cycle after a linked load or a succeeding store is accepted until that operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction strobe, taken when `op_ready` is high |
| op_is_store | input | 1 | 0 = linked load, 1 = conditional store |
| op_addr | input | AW | Address register value |
| op_wdata | input | DW | Store data register value |
| op_ready | output | 1 | Block idle and able to take an operation |
| exc_clear | input | 1 | Interrupt or exception taken; drops the reservation |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| ld_done | output | 1 | One-cycle strobe: loaded word on `ld_data` |
| ld_data | output | DW | Loaded word for the destination register |
| st_done | output | 1 | One-cycle strobe: conditional store decided and finished |
| t_bit | output | 1 | T status bit: result of the last conditional store |

## Verification
Each result has a fixed delay after the event that triggers it:
- A linked load's request is raised the cycle after the strobe is taken.
- `ld_done` rises one cycle after the read response.
- A failing conditional store raises `st_done` in the cycle right after acceptance. A succeeding one raises it in the cycle after its write handshake completes.
- `t_bit` changes on the acceptance edge and is valid by the time `st_done` is high.

The bench does not count cycles. It queues the expected result at issue and compares it at the falling edge on which `ld_done` or `st_done` is seen. Under stalled `mem_req_ready`, it samples `op_ready` and the held request a few cycles after acceptance.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;
  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_RD_REQ  = 2'd1,
    S_RD_WAIT = 2'd2,
    S_WR_REQ  = 2'd3
  } seq_state_t;

  // Next value of the reservation: clearing events win over a new load.
  function automatic logic link_next(input logic cur, input logic ll,
                                     input logic sc, input logic clr);
    if (clr || sc) return 1'b0;
    if (ll)        return 1'b1;
    return cur;
  endfunction

  // A conditional store commits exactly when the reservation is held.
  function automatic logic sc_commits(input logic link);
    return link;
  endfunction
endpackage

// File: rtl/llsc_link_flag.sv
`timescale 1ns/1ps
module llsc_link_flag
  import llsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ll_fire,
  input  logic sc_fire,
  input  logic exc_clear,
  output logic link_q,
  output logic t_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      t_q    <= 1'b0;
    end else begin
      link_q <= link_next(link_q, ll_fire, sc_fire, exc_clear);
      if (sc_fire) t_q <= sc_commits(link_q);
    end
  end

  p_ll_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_fire && !exc_clear) |=> link_q);
  p_sc_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fire |=> !link_q);
  p_exc_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_clear |=> !link_q);
  p_relink_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q && ll_fire && !exc_clear) |=> link_q);
  p_t_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fire |=> (t_q == $past(link_q)));
endmodule

// File: rtl/llsc_seq.sv
`timescale 1ns/1ps
module llsc_seq
  import llsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_is_store,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  input  logic          link_q,
  output logic          op_ready,
  output logic          ll_fire,
  output logic          sc_fire,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          ld_done,
  output logic [DW-1:0] ld_data,
  output logic          st_done
);
  seq_state_t    state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          accept;
  logic          req_fire;

  assign op_ready      = (state == S_IDLE);
  assign accept        = op_valid && op_ready;
  assign ll_fire       = accept && !op_is_store;
  assign sc_fire       = accept && op_is_store;
  assign mem_req_valid = (state == S_RD_REQ) || (state == S_WR_REQ);
  assign mem_req_write = (state == S_WR_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;
  assign req_fire      = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      ld_data <= '0;
      ld_done <= 1'b0;
      st_done <= 1'b0;
    end else begin
      ld_done <= 1'b0;
      st_done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            addr_q  <= op_addr;
            wdata_q <= op_wdata;
          end
          if (ll_fire) state <= S_RD_REQ;
          if (sc_fire) begin
            if (sc_commits(link_q)) state <= S_WR_REQ;
            else                    st_done <= 1'b1;
          end
        end
        S_RD_REQ:  if (req_fire) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          ld_data <= mem_rsp_data;
          ld_done <= 1'b1;
          state   <= S_IDLE;
        end
        S_WR_REQ: if (req_fire) begin
          st_done <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)));
  p_busy_after_ll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ll_fire |=> !op_ready);
  p_ld_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> (ld_data == $past(mem_rsp_data)));
endmodule

// File: rtl/llsc_unit.sv
`timescale 1ns/1ps
module llsc_unit
  import llsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_is_store,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          op_ready,
  input  logic          exc_clear,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          ld_done,
  output logic [DW-1:0] ld_data,
  output logic          st_done,
  output logic          t_bit
);
  logic link_q;
  logic ll_fire;
  logic sc_fire;

  llsc_link_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ll_fire(ll_fire), .sc_fire(sc_fire),
    .exc_clear(exc_clear), .link_q(link_q), .t_q(t_bit)
  );

  llsc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_store(op_is_store),
    .op_addr(op_addr), .op_wdata(op_wdata), .link_q(link_q),
    .op_ready(op_ready), .ll_fire(ll_fire), .sc_fire(sc_fire),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .ld_done(ld_done), .ld_data(ld_data),
    .st_done(st_done)
  );

  p_write_needs_t_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> t_bit);
  p_one_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_done, st_done}));
  p_fail_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fire && !link_q) |=> !mem_req_valid);
endmodule

// File: tb/tb_llsc_unit.sv
`timescale 1ns/1ps
module tb_llsc_unit;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_is_store = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_wdata = '0;
  logic          op_ready;
  logic          exc_clear = 1'b0;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic          ld_done;
  logic [DW-1:0] ld_data;
  logic          st_done;
  logic          t_bit;

  always #2 clk = ~clk;

  llsc_unit #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_store(op_is_store),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_ready(op_ready),
    .exc_clear(exc_clear), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ld_done(ld_done), .ld_data(ld_data), .st_done(st_done), .t_bit(t_bit)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model: word-indexed, one-cycle read response.
  logic          stall = 1'b0;
  logic [DW-1:0] mem_model [16];
  int            wr_count;
  logic [AW-1:0] last_wr_addr;
  logic [DW-1:0] last_wr_data;
  assign mem_req_ready = !stall;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem_model[i] <= 32'hC0DE_0000 + 32'(i * 17);
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      wr_count      <= 0;
      last_wr_addr  <= '0;
      last_wr_data  <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem_model[mem_req_addr[5:2]] <= mem_req_wdata;
          wr_count     <= wr_count + 1;
          last_wr_addr <= mem_req_addr;
          last_wr_data <= mem_req_wdata;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem_model[mem_req_addr[5:2]];
        end
      end
    end
  end

  // Scoreboard
  typedef struct {
    bit          is_st;
    logic [31:0] data;
    logic [31:0] addr;
    bit          t;
    int          wr;
    string       req;
  } exp_item_t;
  exp_item_t     exp_q[$];
  logic [31:0]   shadow [16];
  bit            exp_link = 1'b0;
  int            exp_wr = 0;

  always @(negedge clk) begin
    if (rst_n && (ld_done || st_done)) begin
      if (exp_q.size() == 0) begin
        chk("R10", 64'(1), 64'(0), "result with nothing queued");
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        chk(it.req, 64'(st_done), 64'(it.is_st), "result kind");
        chk(it.req, 64'(wr_count), 64'(it.wr), "memory write count");
        if (!it.is_st) begin
          chk(it.req, 64'(ld_data), 64'(it.data), "loaded word");
        end else begin
          chk(it.req, 64'(t_bit), 64'(it.t), "T bit");
          if (it.t) begin
            chk(it.req, 64'(last_wr_addr), 64'(it.addr), "write address");
            chk(it.req, 64'(last_wr_data), 64'(it.data), "write data");
          end
        end
      end
    end
  end

  task automatic issue(input bit st, input int idx, input logic [31:0] d,
                       input string req);
    exp_item_t it;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    it.is_st = st;
    it.addr  = 32'(idx) << 2;
    it.req   = req;
    if (!st) begin
      exp_link = 1'b1;
      it.data  = shadow[idx];
      it.t     = 1'b0;
    end else begin
      it.t     = exp_link;
      it.data  = d;
      if (exp_link) begin
        shadow[idx] = d;
        exp_wr++;
      end
      exp_link = 1'b0;
    end
    it.wr = exp_wr;
    exp_q.push_back(it);
    op_valid    = 1'b1;
    op_is_store = st;
    op_addr     = 32'(idx) << 2;
    op_wdata    = d;
    @(negedge clk);
    op_valid    = 1'b0;
  endtask

  task automatic pulse_exc();
    @(negedge clk);
    exc_clear = 1'b1;
    @(negedge clk);
    exc_clear = 1'b0;
    exp_link  = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((exp_q.size() != 0 || !op_ready) && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = 32'hC0DE_0000 + 32'(i * 17);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", 64'(t_bit), 64'(0), "T after reset");
    chk("R1", 64'(op_ready), 64'(1), "op_ready after reset");
    chk("R1", 64'(mem_req_valid), 64'(0), "request after reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", 64'(mem_req_valid), 64'(0), "idle request after reset");

    // R1 R4 R5: first store with no reservation fails, no write
    issue(1'b1, 2, 32'h1111_2222, "R1");
    drain();

    // R2 R3 R5: load then store succeeds; R6: second store fails
    issue(1'b0, 3, '0, "R2");
    issue(1'b1, 3, 32'hDEAD_BEEF, "R5");
    issue(1'b1, 3, 32'h0BAD_0BAD, "R6");
    drain();
    // R2: reading back the stored word
    issue(1'b0, 3, '0, "R2");
    drain();

    // R8: repeated linked load keeps the reservation
    issue(1'b0, 5, '0, "R8");
    issue(1'b0, 6, '0, "R8");
    issue(1'b1, 6, 32'h6666_0006, "R8");
    drain();

    // R7: exception between the pair drops the reservation
    issue(1'b0, 7, '0, "R7");
    drain();
    pulse_exc();
    issue(1'b1, 7, 32'h7777_0007, "R7");
    drain();

    // R9 R10 R7: stalled read, exception while the load is in flight
    stall = 1'b1;
    issue(1'b0, 8, '0, "R9");
    repeat (3) @(negedge clk);
    chk("R10", 64'(op_ready), 64'(0), "busy during stalled read");
    chk("R9", 64'(mem_req_valid), 64'(1), "read request held");
    chk("R9", 64'(mem_req_addr), 64'(32'd8 << 2), "read address held");
    pulse_exc();
    stall = 1'b0;
    drain();
    issue(1'b1, 8, 32'h8888_0008, "R7");
    drain();

    // R9 R5 R4: stalled write of a succeeding store
    issue(1'b0, 9, '0, "R3");
    drain();
    stall = 1'b1;
    issue(1'b1, 9, 32'h9999_0009, "R5");
    repeat (3) @(negedge clk);
    chk("R9", 64'(mem_req_write), 64'(1), "write request held");
    chk("R9", 64'(mem_req_wdata), 64'(32'h9999_0009), "write data held");
    chk("R4", 64'(t_bit), 64'(1), "T set at store decision");
    stall = 1'b0;
    drain();
    issue(1'b0, 9, '0, "R2");
    issue(1'b1, 1, 32'h0101_0101, "R4");
    drain();
    chk("R4", 64'(t_bit), 64'(1), "T holds between stores");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule